// File: doc/BRIEF.md
# Tagged Multi-Channel Result Queue

This block gathers conversion results from up to seven independent producer channels and funnels them into a single shared first-in first-out queue. Each stored entry keeps three things together: the result word, the 3-bit number of the channel that produced it, and a flag that marks the result as signed. A consumer reads the oldest entry from a read port, and a one-cycle pop strobe removes it.

Each producer offers a result with a one-cycle valid strobe plus its data and sign. Producer results pass through a one-deep holding register per channel. A fixed-priority selector then moves one held result per cycle into the queue, and the lowest channel number wins. Software-facing controls cover the rest. A global enable flushes the queue when it is low. A per-channel mask admits or rejects each producer. An interrupt enable routes the ready condition to an interrupt line. A sticky overflow error records every result that had to be dropped, and it is cleared by a write-one pulse.

Top module: `conv_tag_fifo`

## Requirements
- R1: Each read returns the oldest entry: `rd_data` is the result word, `rd_id` is the producing channel's port index (0 to 6) as a 3-bit number, and `rd_sign` is the sign bit presented with that result. Entries come out in the order they were written.
- R2: A result on channel i while `cfg_src_en[i]` is 0 is not stored, and `occ_count` does not change.
- R3: While `cfg_fifo_en` is 0, the queue and all holding registers are emptied at each clock edge, `occ_count` reads 0 after the first edge, and producer strobes and pops have no effect.
- R4: `occ_count` is 8 bits wide, gives the number of stored entries, and never exceeds DEPTH (default 16).
- R5: `rd_ready` is 1 exactly when `occ_count` is at least 1.
- R6: `irq` equals `rd_ready` when `cfg_irq_en` is 1, and is 0 when `cfg_irq_en` is 0.
- R7: `ovf_err` stays set until a cycle with `ovf_clr` high, which clears it at the next edge. A new overflow in that same cycle keeps it set.
- R8: A held result selected for writing while the queue holds DEPTH entries is dropped and sets `ovf_err`, and the stored entries are unchanged.
- R9: When several enabled channels present results in the same cycle, they are written in ascending channel order, one per cycle.
- R10: A result arriving on a channel whose holding register is occupied and not selected in that cycle is dropped and sets `ovf_err`.
- R11: A result sampled at clock edge n, with no lower channel pending, is counted in `occ_count` after edge n+1 and not before.
- R12: A pop while `rd_ready` is 1 removes the head at the next edge. A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | Global queue enable; low flushes |
| cfg_src_en | input | N_SRC | Per-channel write admit mask |
| cfg_irq_en | input | 1 | Interrupt enable for the ready condition |
| src_valid | input | N_SRC | One-cycle result strobe per channel |
| src_data | input | N_SRC*DATA_W | Result words, channel i at bits i*DATA_W upward |
| src_sign | input | N_SRC | Signed-result flag per channel |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | DATA_W | Head result word |
| rd_id | output | 3 | Head producing-channel number |
| rd_sign | output | 1 | Head signed flag |
| occ_count | output | CNT_W | Number of stored entries |
| rd_ready | output | 1 | At least one entry stored |
| irq | output | 1 | Ready interrupt |
| ovf_clr | input | 1 | Write-one pulse clearing the overflow error |
| ovf_err | output | 1 | Sticky dropped-result error |

## Verification
A broken holding register or a broken selector shows up at the read port as a wrong channel number, or as entries out of order, within seven cycles of a multi-channel burst. It can also show as a count that is one short, together with a spurious `ovf_err`. A corrupted pointer or count is visible at the next pop as stale data, or as `rd_ready` disagreeing with `occ_count`. A flush that fails to clear state leaves a nonzero count one cycle after the enable drops. A stuck or missing overflow flag is visible on the cycle after the dropped result.

// File: rtl/tagfifo_pkg.sv
// Shared constants for the tagged result queue.
// Assumes at most seven producers so the channel number fits in three bits.
package tagfifo_pkg;
    localparam int SRC_ID_W = 3;
    localparam int MAX_SRC  = 7;
endpackage

// File: rtl/tagfifo_hold.sv
// One-deep holding register for a single producer channel.
// Loads a new result when empty or when drained in the same cycle;
// otherwise the arriving result is reported as dropped.
// Assumes drain is only asserted while hold_vld is 1.
module tagfifo_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sign,
    input  logic              drain,
    output logic              hold_vld,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_sign,
    output logic              drop
);
    logic accept;

    // Accept when free now or freed by this cycle's drain.
    always_comb begin
        accept = in_vld && (!hold_vld || drain) && !flush;
        drop   = in_vld && hold_vld && !drain && !flush;
    end

    // Occupancy flag of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_vld <= 1'b0;
        else if (flush)  hold_vld <= 1'b0;
        else if (accept) hold_vld <= 1'b1;
        else if (drain)  hold_vld <= 1'b0;
    end

    // Payload capture of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_sign <= 1'b0;
        end else if (accept) begin
            hold_data <= in_data;
            hold_sign <= in_sign;
        end
    end
endmodule

// File: rtl/tagfifo_arb.sv
// Fixed-priority selector: the lowest-numbered requesting channel wins.
// Purely combinational; returns a one-hot grant and its binary index.
module tagfifo_arb
    import tagfifo_pkg::*;
#(
    parameter int N_SRC = 7
) (
    input  logic [N_SRC-1:0]    req,
    output logic                gnt_vld,
    output logic [N_SRC-1:0]    gnt_oh,
    output logic [SRC_ID_W-1:0] gnt_idx
);
    // Scan from the top down so the lowest requester is the last written.
    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_oh    = '0;
                gnt_oh[i] = 1'b1;
                gnt_idx   = SRC_ID_W'(i);
            end
        end
        gnt_vld = |req;
    end
endmodule

// File: rtl/tagfifo_store.sv
// Circular entry store with read/write pointers and an occupancy count.
// Pushes while full and pops while empty are ignored here; the caller
// is responsible for reporting the dropped push. Flush has priority.
module tagfifo_store #(
    parameter int EW    = 20,
    parameter int DEPTH = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [EW-1:0]    wr_entry,
    input  logic             pop,
    output logic [EW-1:0]    head,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [EW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    // Qualify requests against the current fill level.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        do_push = push && !full && !flush;
        do_pop  = pop && (count != '0) && !flush;
        head    = mem[rd_ptr];
    end

    // Pointer advance with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)       count <= '0;
        else if (do_push && !do_pop) count <= count + 1'b1;
        else if (do_pop && !do_push) count <= count - 1'b1;
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_entry;
    end
endmodule

// File: rtl/conv_tag_fifo.sv
// Tagged multi-channel result queue top.
// Producer strobes pass through per-channel holding registers, a
// lowest-first selector moves one held result per cycle into the store,
// and each entry is tagged with channel number and sign flag.
// Assumes N_SRC <= 7 and CNT_W wide enough to hold DEPTH.
module conv_tag_fifo
    import tagfifo_pkg::*;
#(
    parameter int N_SRC  = 7,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_fifo_en,
    input  logic [N_SRC-1:0]        cfg_src_en,
    input  logic                    cfg_irq_en,
    input  logic [N_SRC-1:0]        src_valid,
    input  logic [N_SRC*DATA_W-1:0] src_data,
    input  logic [N_SRC-1:0]        src_sign,
    input  logic                    rd_pop,
    output logic [DATA_W-1:0]       rd_data,
    output logic [SRC_ID_W-1:0]     rd_id,
    output logic                    rd_sign,
    output logic [CNT_W-1:0]        occ_count,
    output logic                    rd_ready,
    output logic                    irq,
    input  logic                    ovf_clr,
    output logic                    ovf_err
);
    localparam int EW = DATA_W + SRC_ID_W + 1;

    logic [N_SRC-1:0]    hold_vld, drop_v, gnt_oh;
    logic [DATA_W-1:0]   hold_data [N_SRC];
    logic [N_SRC-1:0]    hold_sign;
    logic                gnt_vld;
    logic [SRC_ID_W-1:0] gnt_idx;
    logic [DATA_W-1:0]   win_data;
    logic                win_sign;
    logic [EW-1:0]       wr_entry, head;
    logic                st_full, ovf_set;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_hold
            tagfifo_hold #(.DATA_W(DATA_W)) u_hold (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (!cfg_fifo_en),
                .in_vld   (src_valid[g] && cfg_src_en[g] && cfg_fifo_en),
                .in_data  (src_data[g*DATA_W +: DATA_W]),
                .in_sign  (src_sign[g]),
                .drain    (gnt_oh[g]),
                .hold_vld (hold_vld[g]),
                .hold_data(hold_data[g]),
                .hold_sign(hold_sign[g]),
                .drop     (drop_v[g])
            );
        end
    endgenerate

    tagfifo_arb #(.N_SRC(N_SRC)) u_arb (
        .req    (hold_vld),
        .gnt_vld(gnt_vld),
        .gnt_oh (gnt_oh),
        .gnt_idx(gnt_idx)
    );

    // Select the winning channel's payload and pack the entry.
    always_comb begin
        win_data = '0;
        win_sign = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (gnt_oh[i]) begin
                win_data = hold_data[i];
                win_sign = hold_sign[i];
            end
        end
        wr_entry = {win_sign, gnt_idx, win_data};
    end

    tagfifo_store #(.EW(EW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!cfg_fifo_en),
        .push    (gnt_vld),
        .wr_entry(wr_entry),
        .pop     (rd_pop),
        .head    (head),
        .full    (st_full),
        .count   (occ_count)
    );

    // Unpack head and derive ready and interrupt.
    always_comb begin
        rd_data  = head[DATA_W-1:0];
        rd_id    = head[DATA_W +: SRC_ID_W];
        rd_sign  = head[EW-1];
        rd_ready = (occ_count != '0);
        irq      = rd_ready && cfg_irq_en;
        ovf_set  = cfg_fifo_en && ((gnt_vld && st_full) || (|drop_v));
    end

    // Sticky overflow error; a new event wins over the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_err <= 1'b0;
        else if (ovf_set) ovf_err <= 1'b1;
        else if (ovf_clr) ovf_err <= 1'b0;
    end
endmodule

// File: rtl/conv_tag_fifo_chk.sv
// Port-level property checker for the tagged result queue, bound to the top.
module conv_tag_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_fifo_en,
    input logic             rd_pop,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] occ_count,
    input logic             rd_ready,
    input logic             ovf_err
);
    p_cnt_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_count) <= DEPTH);

    p_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |=> occ_count == '0);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !ovf_clr) |=> ovf_err);

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occ_count) == DEPTH && !rd_pop && cfg_fifo_en) |=> int'(occ_count) == DEPTH);

    p_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fifo_en |=> (int'(occ_count) <= int'($past(occ_count)) + 1) &&
                        (int'(occ_count) + 1 >= int'($past(occ_count))));

    p_ready_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_ready) |-> $past(cfg_fifo_en));
endmodule

bind conv_tag_fifo conv_tag_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_fifo_en(cfg_fifo_en),
    .rd_pop     (rd_pop),
    .ovf_clr    (ovf_clr),
    .occ_count  (occ_count),
    .rd_ready   (rd_ready),
    .ovf_err    (ovf_err)
);

// File: tb/conv_tag_fifo_bench.sv
module conv_tag_fifo_bench;
    localparam int N = 7;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fifo_en = 1'b0;
    logic [N-1:0] cfg_src_en = '0;
    logic cfg_irq_en = 1'b0;
    logic [N-1:0] src_valid = '0;
    logic [N*DW-1:0] src_data = '0;
    logic [N-1:0] src_sign = '0;
    logic rd_pop = 1'b0;
    logic ovf_clr = 1'b0;
    logic [DW-1:0] rd_data;
    logic [2:0] rd_id;
    logic rd_sign;
    logic [CW-1:0] occ_count;
    logic rd_ready, irq, ovf_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    conv_tag_fifo #(.N_SRC(N), .DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_conv_tag_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_src_en(cfg_src_en),
        .cfg_irq_en(cfg_irq_en), .src_valid(src_valid), .src_data(src_data),
        .src_sign(src_sign), .rd_pop(rd_pop), .rd_data(rd_data), .rd_id(rd_id),
        .rd_sign(rd_sign), .occ_count(occ_count), .rd_ready(rd_ready), .irq(irq),
        .ovf_clr(ovf_clr), .ovf_err(ovf_err)
    );

    // Vector fields: valid mask, enable mask, sign mask, base word.
    localparam logic [36:0] VEC [6] = '{
        {7'b0000001, 7'b1111111, 7'b0000000, 16'h0100},
        {7'b1111111, 7'b1111111, 7'b1010101, 16'h0A00},
        {7'b1111111, 7'b0101010, 7'b1111111, 16'h1234},
        {7'b1000000, 7'b0111111, 7'b0000000, 16'h0200},
        {7'b1100110, 7'b1110111, 7'b0100000, 16'hF000},
        {7'b0011000, 7'b1111111, 7'b0010000, 16'h7FF0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input logic [2:0] id,
                              input logic [15:0] data, input logic sg);
        check(req, {11'd0, rd_ready, rd_sign, rd_id, rd_data}, {11'd0, 1'b1, sg, id, data});
        rd_pop = 1'b1;
        step(1);
        rd_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state
        check("R4 reset count", 32'(occ_count), 0);
        check("R5 reset ready", 32'(rd_ready), 0);
        check("R7 reset ovf", 32'(ovf_err), 0);
        cfg_fifo_en = 1'b1;
        step(1);

        // Table walk: R1 R2 R9
        for (int v = 0; v < 6; v++) begin
            int exp_n;
            logic [6:0] vm, em, sm;
            logic [15:0] base;
            vm = VEC[v][36:30]; em = VEC[v][29:23]; sm = VEC[v][22:16]; base = VEC[v][15:0];
            cfg_src_en = em;
            src_sign = sm;
            for (int i = 0; i < N; i++) src_data[i*DW +: DW] = base + 16'(i);
            src_valid = vm;
            step(1);
            src_valid = '0;
            step(10);
            exp_n = 0;
            for (int i = 0; i < N; i++) if (vm[i] && em[i]) exp_n++;
            check("R2 count after burst", 32'(occ_count), 32'(exp_n));
            check("R5 ready after burst", 32'(rd_ready), 32'(exp_n != 0));
            for (int i = 0; i < N; i++)
                if (vm[i] && em[i]) pop_expect("R1 R9 entry order", 3'(i), base + 16'(i), sm[i]);
            check("R12 empty after pops", 32'(occ_count), 0);
        end

        // R11 latency
        cfg_src_en = '1;
        src_sign = '0;
        src_data[DW*3 +: DW] = 16'h0333;
        src_valid = 7'b0001000;
        step(1);
        src_valid = '0;
        check("R11 not yet counted", 32'(occ_count), 0);
        step(1);
        check("R11 counted after second edge", 32'(occ_count), 1);
        // R12 pop on empty
        pop_expect("R12 single entry", 3'd3, 16'h0333, 1'b0);
        rd_pop = 1'b1;
        step(1);
        rd_pop = 1'b0;
        check("R12 pop while empty", 32'(occ_count), 0);

        // Fill to full on channel 0
        for (int k = 0; k < DEPTH; k++) begin
            src_data[0 +: DW] = 16'(k + 16'h0500);
            src_valid = 7'b0000001;
            step(1);
        end
        src_valid = '0;
        step(2);
        check("R4 full count", 32'(occ_count), DEPTH);
        check("R7 no ovf before extra", 32'(ovf_err), 0);
        check("R6 irq masked", 32'(irq), 0);
        cfg_irq_en = 1'b1;
        #1;
        check("R6 irq enabled", 32'(irq), 1);
        src_data[0 +: DW] = 16'hDEAD;
        src_valid = 7'b0000001;
        step(1);
        src_valid = '0;
        step(2);
        check("R8 count unchanged on full", 32'(occ_count), DEPTH);
        check("R8 ovf set", 32'(ovf_err), 1);
        step(3);
        check("R7 ovf sticky", 32'(ovf_err), 1);
        pop_expect("R8 head intact", 3'd0, 16'h0500, 1'b0);
        ovf_clr = 1'b1;
        step(1);
        ovf_clr = 1'b0;
        check("R7 ovf cleared", 32'(ovf_err), 0);

        // R3 flush and ignore while disabled
        cfg_fifo_en = 1'b0;
        step(1);
        check("R3 flushed count", 32'(occ_count), 0);
        check("R6 irq after flush", 32'(irq), 0);
        src_valid = '1;
        rd_pop = 1'b1;
        step(1);
        src_valid = '0;
        rd_pop = 1'b0;
        step(2);
        check("R3 strobes ignored", 32'(occ_count), 0);
        cfg_fifo_en = 1'b1;
        step(10);
        check("R3 nothing after enable", 32'(occ_count), 0);

        // R10 collision on occupied holding registers
        for (int i = 0; i < N; i++) src_data[i*DW +: DW] = 16'(16'h0C00 + i);
        src_valid = '1;
        step(1);
        src_data[0 +: DW] = 16'h0CFF;
        step(1);
        src_valid = '0;
        step(10);
        check("R10 ovf on busy hold", 32'(ovf_err), 1);
        check("R10 count", 32'(occ_count), 8);
        pop_expect("R10 first", 3'd0, 16'h0C00, 1'b0);
        pop_expect("R10 second", 3'd0, 16'h0CFF, 1'b0);
        pop_expect("R10 third", 3'd1, 16'h0C01, 1'b0);

        finish_run();
    end
endmodule